// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM that holds 64 words. A host places a 6-bit word address on the address input and raises the start strobe. The block then drives chip select, the shift clock and the serial data line toward the memory, samples the memory's serial output and assembles the word. When the transfer is complete, it returns the word together with a single-cycle done pulse.

The request goes out as an 11-bit frame, most significant bit first. The frame is two leading zeros, a start bit of 1, the read opcode `10` and the six address bits. Each frame bit takes three serial phases: clock low with data set up, clock high, then clock low again with data held. Sixteen data clocks follow. Each has a high phase, at whose end the memory output is sampled, and a low phase. Every serial phase lasts a fixed number of system clocks, set by a parameter. Only reads are built. The write (`01`) and erase (`11`) opcodes are defined as constants for neighbouring logic but are never issued.

Top module: `sprom_rd_top`

## Requirements
- R1: The command frame, with bit 10 sent first, is 0, 0, 1, 1, 0, A5, A4, A3, A2, A1, A0. Frame bits 10:9 are zero, bit 8 is the start bit, bits 7:6 are the read opcode `10` and bits 5:0 are the word address latched at the accepted start.
- R2: Each command bit takes three phases in this order: shift clock low, shift clock high, shift clock low. The data line carries the frame bit for all three phases, so it is set up before the rising shift clock and held after it.
- R3: After the 11 command bits come exactly 16 data clocks. Each is one high phase followed by one low phase, with the data line low. A whole access therefore produces 27 rising shift clock edges.
- R4: The memory output is sampled at the end of each data high phase and shifted in most significant bit first. The read data output equals the addressed word in the cycle of the done pulse.
- R5: Chip select rises one phase before the first command bit and stays high until the end of the last data low phase. It is low in the done cycle and whenever the block is idle. The shift clock is only high while chip select is high.
- R6: Every serial phase (select lead-in, command phase, data phase) lasts exactly DIV system clocks. A DIV value below 1 is treated as 1.
- R7: Busy rises in the cycle after an accepted start and stays high through the done cycle, for 66*DIV+1 cycles in total.
- R8: Done is a single-cycle pulse. The read data output keeps its value while the block is idle, until the data phase of the next access.
- R9: A start strobe while busy is high is ignored. The waveform in progress and its address are unchanged, and no extra access follows.
- R10: During and after reset, chip select, shift clock, data line, busy and done are low and the read data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when busy is low |
| addr_i | input | ADDR_W | Word address, latched with an accepted start |
| busy_o | output | 1 | High while an access is in progress |
| done_o | output | 1 | One-cycle pulse when read data is valid |
| rd_data_o | output | DATA_W | Word read from the memory |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Shift clock to the memory |
| di_o | output | 1 | Serial data toward the memory |
| do_i | input | 1 | Serial data from the memory |

## Verification
A wrong phase counter or a wrong divider count shows as a shift clock edge in the wrong cycle. The bench compares chip select, shift clock, data line, busy and done against its own model on every cycle, so such an error is caught within one phase. A wrong bit index or a stale latched address corrupts the data line during the command bits. The bench reports this on the same cycle, and the behavioural memory reports it again through the frame it decoded when done arrives. A capture error, such as sampling in the wrong phase or shifting in the wrong order, only becomes visible in the done cycle, where the returned word is compared with the model's word. If idle-state logic wrongly accepts a start while busy, the bench sees an extra or restarted waveform within one phase.

// File: rtl/sprom_rd_pkg.sv
package sprom_rd_pkg;

    // Controller state encoding
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEL  = 3'd1,
        ST_CMD  = 3'd2,
        ST_DAT  = 3'd3,
        ST_DONE = 3'd4
    } st_e;

    // Opcode field values (bits 7:6 of the frame)
    localparam int         OPC_W     = 2;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    // Leading zero bits sent ahead of the start bit
    localparam int LEAD_W = 2;

    // Serial phases per bit
    localparam int CMD_PHASES = 3;
    localparam int DAT_PHASES = 2;

    function automatic int frame_width(input int addr_w);
        return LEAD_W + 1 + OPC_W + addr_w;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sprom_rd_tick.sv
module sprom_rd_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PH = (DIV < 1) ? 1 : DIV;
    localparam int CW = (PH > 1) ? $clog2(PH) : 1;
    localparam logic [CW-1:0] LAST = CW'(PH - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sprom_rd_frame.sv
module sprom_rd_frame
    import sprom_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0]      addr_i,
    output logic [(1<<IDX_W)-1:0]  frame_o
);
    localparam int FRAME_W = frame_width(ADDR_W);

    logic [FRAME_W-1:0] frame_w;

    assign frame_w = {{LEAD_W{1'b0}}, 1'b1, OPC_READ, addr_i};

    always_comb begin
        frame_o = '0;
        frame_o[FRAME_W-1:0] = frame_w;
    end

endmodule

// File: rtl/sprom_rd_capture.sv
module sprom_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_i) begin
            word_d = {word_q[DATA_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/sprom_rd_top.sv
module sprom_rd_top
    import sprom_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int DIV    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              do_i
);
    localparam int FRAME_W = frame_width(ADDR_W);
    localparam int IDX_W   = $clog2(max2(FRAME_W, DATA_W));
    localparam logic [1:0] CMD_LAST = 2'(CMD_PHASES - 1);
    localparam logic [1:0] DAT_LAST = 2'(DAT_PHASES - 1);
    localparam logic [1:0] SK_CMD   = 2'd1;
    localparam logic [1:0] SK_DAT   = 2'd0;

    typedef struct packed {
        st_e               st;
        logic [1:0]        sub;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic              cs;
        logic              sk;
        logic              di;
        logic              busy;
        logic              done;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:   ST_IDLE,
        sub:  2'd0,
        idx:  '0,
        addr: '0,
        cs:   1'b0,
        sk:   1'b0,
        di:   1'b0,
        busy: 1'b0,
        done: 1'b0
    };

    regs_t r_q, r_d;
    logic  tick;
    logic  run;
    logic  shift_en;
    logic [(1<<IDX_W)-1:0] frame_w;

    assign run = (r_q.st == ST_SEL) || (r_q.st == ST_CMD) || (r_q.st == ST_DAT);

    sprom_rd_tick #(
        .DIV (DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    sprom_rd_frame #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_frame (
        .addr_i  (r_q.addr),
        .frame_o (frame_w)
    );

    sprom_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_en),
        .bit_i   (do_i),
        .word_o  (rd_data_o)
    );

    always_comb begin
        r_d      = r_q;
        shift_en = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_SEL;
                    r_d.addr = addr_i;
                    r_d.sub  = 2'd0;
                end
            end
            ST_SEL: begin
                if (tick) begin
                    r_d.st  = ST_CMD;
                    r_d.idx = IDX_W'(FRAME_W - 1);
                    r_d.sub = 2'd0;
                end
            end
            ST_CMD: begin
                if (tick) begin
                    if (r_q.sub == CMD_LAST) begin
                        r_d.sub = 2'd0;
                        if (r_q.idx == '0) begin
                            r_d.st  = ST_DAT;
                            r_d.idx = IDX_W'(DATA_W - 1);
                        end else begin
                            r_d.idx = r_q.idx - 1'b1;
                        end
                    end else begin
                        r_d.sub = r_q.sub + 1'b1;
                    end
                end
            end
            ST_DAT: begin
                if (tick) begin
                    if (r_q.sub == DAT_LAST) begin
                        r_d.sub = 2'd0;
                        if (r_q.idx == '0) begin
                            r_d.st = ST_DONE;
                        end else begin
                            r_d.idx = r_q.idx - 1'b1;
                        end
                    end else begin
                        // end of the high phase: take the memory output
                        shift_en = (r_q.sub == SK_DAT);
                        r_d.sub  = r_q.sub + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // Pin values follow the next state so that they leave a flop
        r_d.cs   = (r_d.st == ST_SEL) || (r_d.st == ST_CMD) || (r_d.st == ST_DAT);
        r_d.sk   = ((r_d.st == ST_CMD) && (r_d.sub == SK_CMD)) ||
                   ((r_d.st == ST_DAT) && (r_d.sub == SK_DAT));
        r_d.di   = (r_d.st == ST_CMD) && frame_w[r_d.idx];
        r_d.busy = (r_d.st != ST_IDLE);
        r_d.done = (r_d.st == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = r_q.busy;
    assign done_o = r_q.done;
    assign cs_o   = r_q.cs;
    assign sk_o   = r_q.sk;
    assign di_o   = r_q.di;

endmodule

// File: rtl/sprom_rd_chk.sv
module sprom_rd_chk
    import sprom_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_o,
    input logic              sk_o,
    input logic              di_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] rd_data_o
);
    localparam int FRAME_W = frame_width(ADDR_W);
    localparam int RISES   = FRAME_W + DATA_W;
    localparam int RW      = $clog2(RISES + 1);

    logic [RW-1:0] rise_q;
    logic          sk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q    <= '0;
            sk_prev_q <= 1'b0;
        end else begin
            sk_prev_q <= sk_o;
            if (!cs_o) begin
                rise_q <= '0;
            end else if (sk_o && !sk_prev_q) begin
                rise_q <= rise_q + 1'b1;
            end
        end
    end

    // R5
    sk_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !cs_o));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    // R10
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cs_o && !sk_o && !di_o && !done_o));

    // R2
    di_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sk_o) && (rise_q < RW'(FRAME_W))) |-> $stable(di_o));

    // R2
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sk_o) && (rise_q <= RW'(FRAME_W))) |-> $stable(di_o));

    // R3
    rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |-> (rise_q == RW'(RISES)));

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> $stable(rd_data_o));

endmodule

bind sprom_rd_top sprom_rd_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_o      (cs_o),
    .sk_o      (sk_o),
    .di_o      (di_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rd_data_o (rd_data_o)
);

// File: tb/sprom_rd_top_tb_top.sv
module sprom_rd_top_tb_top;
    localparam int PH = 3;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          busy, done, cs, sk, di;
    logic          mem_do = 1'b0;
    logic [DW-1:0] rdata;

    always #4 clk = ~clk;

    sprom_rd_top #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .DIV    (PH)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .addr_i    (addr),
        .busy_o    (busy),
        .done_o    (done),
        .rd_data_o (rdata),
        .cs_o      (cs),
        .sk_o      (sk),
        .di_o      (di),
        .do_i      (mem_do)
    );

    typedef struct {
        logic          cs, sk, di, busy, done;
        logic [DW-1:0] word;
        logic [10:0]   frame;
    } exp_t;

    exp_t          q[$];
    int            checks = 0;
    int            errors = 0;
    bit            cur_busy = 1'b0;
    bit            ign_seen = 1'b0;
    bit            finished = 1'b0;
    logic [DW-1:0] last_word = '0;

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        logic [DW-1:0] w;
        if (a == 6'd5)      w = 16'hFFFF;
        else if (a == 6'd6) w = 16'h0000;
        else                w = (16'(a) * 16'h1357) ^ 16'hA5C3;
        return w;
    endfunction

    function automatic logic [10:0] frame_of(input logic [AW-1:0] a);
        return {2'b00, 1'b1, 2'b10, a};
    endfunction

    // Behavioural three-wire memory
    int          s_cnt = 0;
    logic [10:0] s_cmd = '0;
    always @(posedge sk or negedge cs) begin
        if (!cs) begin
            s_cnt  = 0;
            mem_do = 1'b0;
        end else begin
            if (s_cnt < 11) begin
                s_cmd = {s_cmd[9:0], di};
            end else begin
                logic [DW-1:0] w;
                w = word_at(s_cmd[5:0]);
                mem_do = w[15 - (s_cnt - 11)];
            end
            s_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic add(input logic c, input logic s, input logic d,
                       input logic b, input logic dn, input int n,
                       input logic [DW-1:0] w, input logic [10:0] f);
        exp_t e;
        e.cs = c; e.sk = s; e.di = d; e.busy = b; e.done = dn;
        e.word = w; e.frame = f;
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    task automatic push_access(input logic [AW-1:0] a);
        logic [10:0] f;
        f = frame_of(a);
        add(1, 0, 0, 1, 0, PH, '0, f);
        for (int b = 10; b >= 0; b--) begin
            add(1, 0, f[b], 1, 0, PH, '0, f);
            add(1, 1, f[b], 1, 0, PH, '0, f);
            add(1, 0, f[b], 1, 0, PH, '0, f);
        end
        for (int k = 0; k < 16; k++) begin
            add(1, 1, 0, 1, 0, PH, '0, f);
            add(1, 0, 0, 1, 0, PH, '0, f);
        end
        add(0, 0, 0, 1, 1, 1, word_at(a), f);
    endtask

    task automatic cyc();
        @(negedge clk);
        if (!rst_n) begin
            chk({cs, sk, di, busy, done} === 5'b0, "R10 pins in reset",
                32'({cs, sk, di, busy, done}), 32'd0);
            chk(rdata === '0, "R10 data in reset", 32'(rdata), 32'd0);
            cur_busy = 1'b0;
        end else if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(cs === e.cs, "R5 chip select", 32'(cs), 32'(e.cs));
            chk(sk === e.sk, "R3,R6 shift clock", 32'(sk), 32'(e.sk));
            chk(di === e.di, "R2 data line", 32'(di), 32'(e.di));
            chk(busy === e.busy, "R7 busy", 32'(busy), 32'(e.busy));
            chk(done === e.done, "R8 done", 32'(done), 32'(e.done));
            if (e.done) begin
                chk(rdata === e.word, ign_seen ? "R4,R9 read word" : "R4 read word",
                    32'(rdata), 32'(e.word));
                chk(s_cmd === e.frame, "R1 frame decoded by memory",
                    32'(s_cmd), 32'(e.frame));
                last_word = e.word;
            end
            cur_busy = e.busy;
        end else begin
            chk({cs, sk, di, busy, done} === 5'b0, "R5,R7 idle pins",
                32'({cs, sk, di, busy, done}), 32'd0);
            chk(rdata === last_word, "R8 data held", 32'(rdata), 32'(last_word));
            cur_busy = 1'b0;
        end
    endtask

    task automatic step(input bit s, input logic [AW-1:0] a);
        cyc();
        start = s;
        addr  = a;
        if (s && rst_n) begin
            if (!cur_busy) begin
                push_access(a);
                ign_seen = 1'b0;
            end else begin
                ign_seen = 1'b1;
            end
        end
    endtask

    task automatic drain();
        while (q.size() > 0) step(0, '0);
    endtask

    task automatic one_read(input logic [AW-1:0] a);
        step(1, a);
        drain();
        repeat (3) step(0, '0);
    endtask

    initial begin
        repeat (4) step(0, '0);
        rst_n = 1'b1;
        repeat (3) step(0, '0);

        one_read(6'h00);
        one_read(6'h3F);
        one_read(6'h05);   // all ones word
        one_read(6'h06);   // all zeros word
        one_read(6'h2A);
        one_read(6'h15);

        // R9: starts during an access with other addresses
        step(1, 6'h21);
        step(1, 6'h0F);
        repeat (40) step(0, '0);
        step(1, 6'h11);
        repeat (120) step(0, '0);
        step(1, 6'h3C);
        drain();
        repeat (5) step(0, '0);

        // start held high: next access begins once busy has dropped
        repeat (2 * (66 * PH + 1) + 6) step(1, 6'h07);
        step(0, '0);
        drain();
        repeat (5) step(0, '0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule